// File: doc/BRIEF.md
# Center-Aligned Dual-Slope PWM Generator

This block produces symmetric pulse-width-modulated waveforms from one shared 16-bit up/down counter. On each enabled prescaler tick the counter steps from zero up to a programmable period limit (the peak), stays there for one tick, then steps back down to zero. Each channel compares the counter with its own duty value and sets or clears its output on the matches. The resulting pulse is centered on the peak, so several channels with different duties never switch together.

The peak and all duty values are written into shadow registers. Each shadow register is copied into its working register only on the tick that leaves the counter minimum. A period or duty change therefore never cuts a cycle short or leaves a partial pulse. Each channel has its own polarity input. A one-cycle strobe marks each return of the counter to zero.

Top module: `pwm_center`

## Requirements
- R1: After reset the counter is 0, `uflow_o` is low, and every `pwm_o[k]` sits at its inactive level: 0 when `inv_i[k]`=0 and 1 when `inv_i[k]`=1.
- R2: The counter advances only on a clock where `en_i` and `tick_i` are both 1. It rises by one per tick from 0 to the active peak, then falls by one per tick back to 0. When either input is 0, the counter, the outputs and the working registers all hold.
- R3: The counter holds the peak value for exactly one tick and then turns downward.
- R4: With an active peak P ≥ 1, one full period lasts 2·P ticks. `uflow_o` is high for exactly one clock, the clock after the tick on which the counter falls to 0. With P = 0 the counter stays at 0 and `uflow_o` pulses once per tick.
- R5: With `inv_i[k]`=0 and 0 < duty < peak, the output is 1 while the counter is below the duty on the way up. It is cleared at the up-slope match. It is set again at the down-slope match, so on the way down it is 1 while the counter is at or below the duty.
- R6: With `inv_i[k]`=1, the output is the complement of the R5 waveform: set at the up-slope match and cleared at the down-slope match.
- R7: A peak written through `top_we_i` becomes active only on the tick at which the counter leaves 0.
- R8: A duty written through `duty_we_i[k]` (data on `duty_wdata_i`) becomes active for channel k only on that same tick. Writes to other channels do not affect channel k.
- R9: With a nonzero active duty at or above the active peak, the output stays 1 for the whole period when not inverted, and 0 when inverted.
- R10: With an active duty of 0, the output stays 0 when not inverted and 1 when inverted. This rule takes priority over R9.
- R11: Each channel has its own duty shadow register, working register and polarity, and the channels operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| tick_i | input | 1 | Prescaler clock-enable pulse |
| top_we_i | input | 1 | Write strobe for the peak shadow register |
| top_wdata_i | input | 16 | Peak write data |
| duty_we_i | input | N_CH | Per-channel write strobe for the duty shadow register |
| duty_wdata_i | input | 16 | Duty write data, shared by all channels |
| inv_i | input | N_CH | Per-channel polarity, 1 = inverting |
| pwm_o | output | N_CH | Channel waveforms |
| uflow_o | output | 1 | One-clock strobe when the counter reaches 0 on the down slope |

## Verification
The assertions check the following on every cycle:
- the counter never exceeds the active peak;
- the strobe only appears at zero;
- the counter turns downward right after the peak;
- the working registers change only on the load tick;
- a zero duty forces the inactive level.

Three behaviours can only be shown by the bench scenarios:
- the period length in ticks;
- where the set and clear edges fall relative to the duty;
- that a shadow write has no effect until the next period starts.

The bench shows these by comparing every output against an independent cycle model, under directed settings and random settings.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_CNT_W = 16;
  typedef logic [PWM_CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_ONE  = cnt_t'(1);
  localparam cnt_t CNT_ZERO = '0;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic top_we_i,
  input  cnt_t top_wdata_i,
  output cnt_t cnt_o,
  output logic up_o,
  output cnt_t top_o,
  output logic load_o,
  output logic uflow_o
);
  cnt_t cnt_q, top_sh_q, top_q;
  logic up_q, uflow_q, step;

  assign step   = en_i & tick_i;
  assign load_o = step & (cnt_q == CNT_ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_ZERO;
      up_q     <= 1'b1;
      top_sh_q <= CNT_ZERO;
      top_q    <= CNT_ZERO;
      uflow_q  <= 1'b0;
    end else begin
      uflow_q <= 1'b0;
      if (top_we_i) top_sh_q <= top_wdata_i;
      if (step) begin
        if (cnt_q == CNT_ZERO) begin
          top_q <= top_sh_q;
          if (top_sh_q == CNT_ZERO) begin
            uflow_q <= 1'b1;
          end else begin
            cnt_q <= CNT_ONE;
            up_q  <= 1'b1;
          end
        end else if (up_q && cnt_q != top_q) begin
          cnt_q <= cnt_q + CNT_ONE;
        end else begin
          up_q    <= 1'b0;
          cnt_q   <= cnt_q - CNT_ONE;
          uflow_q <= (cnt_q == CNT_ONE);
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign up_o    = up_q;
  assign top_o   = top_q;
  assign uflow_o = uflow_q;

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_q);
  p_hold_no_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(cnt_q));
  p_peak_turn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && up_q && cnt_q == top_q && cnt_q != CNT_ZERO) |=> (!up_q && cnt_q == $past(cnt_q) - CNT_ONE));
  p_uflow_at_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_q |-> cnt_q == CNT_ZERO);
  p_uflow_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflow_q && !step) |=> !uflow_q);
  p_top_only_at_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(top_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cnt_t cnt_i,
  input  logic up_i,
  input  cnt_t top_i,
  input  logic we_i,
  input  cnt_t wdata_i,
  input  logic inv_i,
  output logic pwm_o
);
  cnt_t duty_sh_q, duty_q;
  logic level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_sh_q <= CNT_ZERO;
      duty_q    <= CNT_ZERO;
    end else begin
      if (we_i)   duty_sh_q <= wdata_i;
      if (load_i) duty_q    <= duty_sh_q;
    end
  end

  // up slope: high below match; down slope: high at or below match
  always_comb begin
    if (duty_q == CNT_ZERO)  level = 1'b0;
    else if (duty_q >= top_i) level = 1'b1;
    else if (up_i)           level = (cnt_i < duty_q);
    else                     level = (cnt_i <= duty_q);
  end

  assign pwm_o = level ^ inv_i;

  p_duty_only_at_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(duty_q));
  p_zero_inactive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == CNT_ZERO) |-> (pwm_o == inv_i));
  p_full_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q != CNT_ZERO && duty_q >= top_i) |-> (pwm_o == !inv_i));
endmodule

// File: rtl/pwm_center.sv
module pwm_center
  import pwm_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 top_we_i,
  input  logic [PWM_CNT_W-1:0] top_wdata_i,
  input  logic [N_CH-1:0]      duty_we_i,
  input  logic [PWM_CNT_W-1:0] duty_wdata_i,
  input  logic [N_CH-1:0]      inv_i,
  output logic [N_CH-1:0]      pwm_o,
  output logic                 uflow_o
);
  cnt_t cnt, top;
  logic up, load;

  pwm_timebase u_tb (
    .clk_i, .rst_ni, .en_i, .tick_i, .top_we_i,
    .top_wdata_i(cnt_t'(top_wdata_i)),
    .cnt_o(cnt), .up_o(up), .top_o(top), .load_o(load), .uflow_o
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pwm_channel u_ch (
      .clk_i, .rst_ni, .load_i(load), .cnt_i(cnt), .up_i(up), .top_i(top),
      .we_i(duty_we_i[k]), .wdata_i(cnt_t'(duty_wdata_i)),
      .inv_i(inv_i[k]), .pwm_o(pwm_o[k])
    );
  end
endmodule

// File: tb/tb_pwm_center.sv
module tb_pwm_center;
  localparam int N = 2;
  logic clk = 0, rst_n = 0, en = 0, tick = 0, top_we = 0;
  logic [15:0] top_wd = 0, duty_wd = 0;
  logic [N-1:0] duty_we = 0, inv = 0, pwm;
  logic uflow;
  int checks = 0, errors = 0;

  // independent reference model
  int m_cnt, m_top, m_tsh;
  bit m_up, m_uf;
  int m_duty[N], m_dsh[N];

  always #10 clk = ~clk;

  pwm_center #(.N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .top_we_i(top_we),
    .top_wdata_i(top_wd), .duty_we_i(duty_we), .duty_wdata_i(duty_wd),
    .inv_i(inv), .pwm_o(pwm), .uflow_o(uflow));

  function automatic bit exp_lvl(int c, bit up, int d, int t, bit iv);
    bit l;
    if (d == 0) l = 0;
    else if (d >= t) l = 1;
    else if (up) l = (c < d);
    else l = (c <= d);
    return l ^ iv;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_top = 0; m_tsh = 0; m_uf = 0;
    for (int k = 0; k < N; k++) begin m_duty[k] = 0; m_dsh[k] = 0; end
  endtask

  task automatic model_step();
    m_uf = 0;
    if (en && tick) begin
      if (m_cnt == 0) begin
        m_top = m_tsh;
        for (int k = 0; k < N; k++) m_duty[k] = m_dsh[k];
        if (m_tsh == 0) m_uf = 1;
        else begin m_cnt = 1; m_up = 1; end
      end else if (m_up && m_cnt != m_top) m_cnt++;
      else begin m_up = 0; m_cnt--; m_uf = (m_cnt == 0); end
    end
    if (top_we) m_tsh = top_wd;
    for (int k = 0; k < N; k++) if (duty_we[k]) m_dsh[k] = duty_wd;
  endtask

  task automatic compare(string tag);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) e[k] = exp_lvl(m_cnt, m_up, m_duty[k], m_top, inv[k]);
    checks++;
    if (pwm !== e || uflow !== m_uf) begin
      errors++;
      $display("FAIL %s pwm=%b uflow=%b expected pwm=%b uflow=%b", tag, pwm, uflow, e, m_uf);
    end
  endtask

  // inputs already applied at negedge; advance one clock and check
  task automatic cyc(string tag);
    model_step();
    @(posedge clk); @(negedge clk);
    top_we = 0; duty_we = '0;
    compare(tag);
  endtask

  task automatic wr_top(int v);
    top_we = 1; top_wd = 16'(v); cyc("R7 top write");
  endtask

  task automatic wr_duty(int k, int v);
    duty_we = '0; duty_we[k] = 1; duty_wd = 16'(v); cyc("R8 R11 duty write");
  endtask

  // measure uflow spacing with tick every cycle
  task automatic period_check(int p);
    int n = 0;
    en = 1; tick = 1;
    while (!uflow) cyc("R2 R4 sync");
    do begin cyc("R4 period"); n++; end while (!uflow && n < 1000);
    checks++;
    if (n != 2 * p) begin
      errors++;
      $display("FAIL R4 period ticks=%0d expected=%0d", n, 2 * p);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    inv = 2'b10;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    // R5 R9 R3: peak 5, ch0 duty 2, ch1 duty 7 non-inverted
    inv = 2'b00;
    wr_top(5); wr_duty(0, 2); wr_duty(1, 7);
    period_check(5);
    repeat (12) cyc("R3 R5 R9 waveform");

    // R6 R10: inverted ch0 duty 3, ch1 duty 0
    inv = 2'b01;
    wr_duty(0, 3); wr_duty(1, 0);
    period_check(5);
    repeat (12) cyc("R6 R10 waveform");

    // R7: new peak written mid-period waits for the period boundary
    en = 1; tick = 1;
    repeat (3) cyc("R7 pre");
    wr_top(3);
    period_check(3);
    // peak 1 and peak 0 corners
    wr_top(1); period_check(1);
    wr_top(0); repeat (6) cyc("R4 zero peak");

    // R2 hold: enable low or tick low
    wr_top(4);
    repeat (10) cyc("R2 run");
    en = 0; repeat (5) cyc("R2 hold en");
    en = 1; tick = 0; repeat (5) cyc("R2 hold tick");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      en = ($urandom % 16) != 0;
      if ($urandom % 10 == 0) begin top_we = 1; top_wd = 16'($urandom % 13); end
      if ($urandom % 6 == 0) begin
        duty_we = 2'($urandom % 4); duty_wd = 16'($urandom % 15);
      end
      if ($urandom % 40 == 0) inv = 2'($urandom % 4);
      cyc("R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule